// File: doc/BRIEF.md
# Accumulator Bit-Field Unit

This block moves bit fields in and out of a 56-bit accumulator. An extract operation picks a field of a given width at a given offset out of a source accumulator and places it, right-justified, in the result, either zero-filled or sign-filled up to the top bit. An insert operation takes the low bits of a 24-bit register and writes them into a destination accumulator at an offset. Every accumulator bit outside the written positions keeps its value.

Width and offset come from one 24-bit control word. That word is either taken from a register in the issue cycle, giving a one-cycle operation, or delivered as an extension word one cycle later, giving a two-cycle operation. While the unit waits for the extension word it raises a request output. The result appears together with the updated N and Z flags, and V and C are reported cleared. Instruction decode and memory access stay outside the block.

Top module: `acc_field_unit`

## Requirements
- R1: The field width is control bits 17:12 and the offset is control bits 5:0. All other control bits have no effect on the result.
- R2: With opKind 2'b00 (unsigned extract), the result is the source accumulator shifted right by the offset and then masked to its low `width` bits. A width of 56 or more leaves the shifted value unmasked, and an offset of 56 or more gives zero.
- R3: With opKind 2'b01 (signed extract), the result equals the unsigned result, except that bits width through 55 are all set to one when width ≥ 1 and bit width−1 of the shifted source is one. Source bits above 55 count as zero.
- R4: With opKind[1] = 1 (2'b10 or 2'b11, insert), the result is the destination accumulator with positions offset to offset+width−1 replaced by bits 0 to width−1 of the 24-bit source register. Field bits at index 24 and above are zero. Positions above 55 are discarded, and every other destination bit is kept.
- R5: A width of zero gives a result of zero for both extracts, and leaves the destination unchanged for an insert.
- R6: With every result, resN equals result bit 55 and resZ is 1 exactly when all 56 result bits are zero. resV and resC are 0.
- R7: With useImm = 0, an operation issued with opValid in cycle t has resValid high, and its result on resAcc, in cycle t+1. needWord stays low.
- R8: With useImm = 1, needWord is high in cycle t+1, when extWord is sampled as the control word together with the operands captured in cycle t. resValid and the result follow in cycle t+2.
- R9: An opValid raised while needWord is high is ignored. No second result follows, and the pending result uses the captured operands.
- R10: After reset, resValid and needWord are low and resAcc is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Issue an operation this cycle |
| opKind | input | 2 | 00 unsigned extract, 01 signed extract, 1x insert |
| useImm | input | 1 | 1: control word arrives next cycle on extWord |
| ctrlReg | input | 24 | Control word from a register (register mode) |
| extWord | input | 24 | Control extension word (sampled while needWord) |
| srcAcc | input | 56 | Source accumulator for extract |
| srcReg | input | 24 | Source register for insert |
| dstAcc | input | 56 | Destination accumulator old value for insert |
| needWord | output | 1 | Unit is consuming the extension word this cycle |
| resValid | output | 1 | Result and flags valid |
| resAcc | output | 56 | New accumulator value |
| resN | output | 1 | Negative flag |
| resZ | output | 1 | Zero flag |
| resV | output | 1 | Overflow flag (always cleared) |
| resC | output | 1 | Carry flag (always cleared) |

## Verification
A stuck or skipped control state shows up at the ports within one cycle. A wrong state makes needWord appear in register mode, makes resValid arrive a cycle early or late, or lets an ignored issue produce a second result. Held operands that are corrupted, or a mux that picks live inputs in the extension cycle, show up in the very result of that operation, because the bench changes every live input during that cycle. A wrong mask or sign-fill position shows up as a bad resAcc or N/Z value. The width and offset sweep reaches every boundary of the 56-bit accumulator.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic fireLive;   // compute from live inputs and ctrlReg
    logic holdOps;    // capture operands, wait for extension word
    logic fireHeld;   // compute from held operands and extWord
  } bfuStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXT  = 1'b1
  } bfuState_e;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       useImm,
  output bfuStrobe_t strobe,
  output logic       needWord
);

  bfuState_e state, stateNext;

  always_comb begin
    strobe          = '0;
    stateNext       = state;
    strobe.fireLive = (state == ST_IDLE) && opValid && !useImm;
    strobe.holdOps  = (state == ST_IDLE) && opValid && useImm;
    strobe.fireHeld = (state == ST_EXT);
    if (strobe.holdOps) stateNext = ST_EXT;
    else if (state == ST_EXT) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign needWord = (state == ST_EXT);

  // R7
  reg_mode_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!needWord && opValid && !useImm) |=> !needWord);

  // R8
  imm_mode_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!needWord && opValid && useImm) |=> needWord);

  // R9
  ext_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    needWord |=> !needWord);

endmodule

// File: rtl/bfu_field.sv
module bfu_field #(
  parameter int ACC_W   = 56,
  parameter int SRC_W   = 24,
  parameter int CTRL_W  = 24,
  parameter int FLD_W   = 6,
  parameter int WID_LSB = 12,
  parameter int OFF_LSB = 0
) (
  input  logic [1:0]        opKind,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [ACC_W-1:0]  srcAcc,
  input  logic [SRC_W-1:0]  srcReg,
  input  logic [ACC_W-1:0]  dstAcc,
  output logic [ACC_W-1:0]  lowMask,
  output logic [ACC_W-1:0]  result
);

  localparam int PAD_W = ACC_W - SRC_W;

  logic [FLD_W-1:0] width, offset;
  logic [31:0]      widthW, offsetW;
  logic [ACC_W-1:0] placeMask;
  logic [ACC_W-1:0] shifted, fieldU, extResult;
  logic [ACC_W-1:0] signPick, srcZext, insField, insResult;
  logic             signBit;
  logic             unusedCtrl;

  assign width      = ctrl[WID_LSB +: FLD_W];
  assign offset     = ctrl[OFF_LSB +: FLD_W];
  assign widthW     = 32'(width);
  assign offsetW    = 32'(offset);
  assign unusedCtrl = ^ctrl;

  // Per-bit masks: low field mask and its placement at the offset
  for (genvar i = 0; i < ACC_W; i++) begin : g_mask
    assign lowMask[i]   = widthW > 32'(i);
    assign placeMask[i] = (offsetW <= 32'(i)) && ((offsetW + widthW) > 32'(i));
  end

  // Extract path
  assign shifted  = srcAcc >> offset;
  assign fieldU   = shifted & lowMask;
  assign signPick = shifted >> (width - 1'b1);
  assign signBit  = (width != '0) && signPick[0];

  always_comb begin
    extResult = fieldU;
    if (opKind[0] && signBit) extResult = fieldU | ~lowMask;
  end

  // Insert path
  assign srcZext   = {{PAD_W{1'b0}}, srcReg};
  assign insField  = (srcZext & lowMask) << offset;
  assign insResult = (dstAcc & ~placeMask) | insField;

  assign result = opKind[1] ? insResult : extResult;

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int ACC_W   = 56,
  parameter int SRC_W   = 24,
  parameter int CTRL_W  = 24,
  parameter int FLD_W   = 6,
  parameter int WID_LSB = 12,
  parameter int OFF_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfuStrobe_t        strobe,
  input  logic [1:0]        opKind,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic [CTRL_W-1:0] extWord,
  input  logic [ACC_W-1:0]  srcAcc,
  input  logic [SRC_W-1:0]  srcReg,
  input  logic [ACC_W-1:0]  dstAcc,
  output logic              resValid,
  output logic [ACC_W-1:0]  resAcc,
  output logic              resN,
  output logic              resZ
);

  logic [1:0]        kindQ;
  logic [ACC_W-1:0]  srcAccQ, dstAccQ;
  logic [SRC_W-1:0]  srcRegQ;

  logic [1:0]        selKind;
  logic [CTRL_W-1:0] selCtrl;
  logic [ACC_W-1:0]  selSrcAcc, selDstAcc, lowMask, fieldRes;
  logic [SRC_W-1:0]  selSrcReg;
  logic              fire;

  assign fire = strobe.fireLive || strobe.fireHeld;

  // Operand hold for the extension-word cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ   <= '0;
      srcAccQ <= '0;
      dstAccQ <= '0;
      srcRegQ <= '0;
    end else if (strobe.holdOps) begin
      kindQ   <= opKind;
      srcAccQ <= srcAcc;
      dstAccQ <= dstAcc;
      srcRegQ <= srcReg;
    end
  end

  always_comb begin
    if (strobe.fireHeld) begin
      selKind   = kindQ;
      selCtrl   = extWord;
      selSrcAcc = srcAccQ;
      selDstAcc = dstAccQ;
      selSrcReg = srcRegQ;
    end else begin
      selKind   = opKind;
      selCtrl   = ctrlReg;
      selSrcAcc = srcAcc;
      selDstAcc = dstAcc;
      selSrcReg = srcReg;
    end
  end

  bfu_field #(
    .ACC_W(ACC_W), .SRC_W(SRC_W), .CTRL_W(CTRL_W),
    .FLD_W(FLD_W), .WID_LSB(WID_LSB), .OFF_LSB(OFF_LSB)
  ) field_i (
    .opKind (selKind),
    .ctrl   (selCtrl),
    .srcAcc (selSrcAcc),
    .srcReg (selSrcReg),
    .dstAcc (selDstAcc),
    .lowMask(lowMask),
    .result (fieldRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resAcc   <= '0;
      resN     <= 1'b0;
      resZ     <= 1'b0;
    end else begin
      resValid <= fire;
      if (fire) begin
        resAcc <= fieldRes;
        resN   <= fieldRes[ACC_W-1];
        resZ   <= ~|fieldRes;
      end
    end
  end

  // R5
  ins_zero_width_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fireLive && opKind[1] && (ctrlReg[WID_LSB +: FLD_W] == '0))
      |=> (resAcc == $past(dstAcc)));

  // R2
  ext_unsigned_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (selKind == 2'b00)) |=> ((resAcc & ~$past(lowMask)) == '0));

  // R8
  held_result_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fireHeld |=> resValid);

endmodule

// File: rtl/acc_field_unit.sv
module acc_field_unit
  import bfu_pkg::*;
#(
  parameter int ACC_W   = 56,
  parameter int SRC_W   = 24,
  parameter int CTRL_W  = 24,
  parameter int FLD_W   = 6,
  parameter int WID_LSB = 12,
  parameter int OFF_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic              useImm,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic [CTRL_W-1:0] extWord,
  input  logic [ACC_W-1:0]  srcAcc,
  input  logic [SRC_W-1:0]  srcReg,
  input  logic [ACC_W-1:0]  dstAcc,
  output logic              needWord,
  output logic              resValid,
  output logic [ACC_W-1:0]  resAcc,
  output logic              resN,
  output logic              resZ,
  output logic              resV,
  output logic              resC
);

  bfuStrobe_t strobe;

  bfu_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .useImm  (useImm),
    .strobe  (strobe),
    .needWord(needWord)
  );

  bfu_datapath #(
    .ACC_W(ACC_W), .SRC_W(SRC_W), .CTRL_W(CTRL_W),
    .FLD_W(FLD_W), .WID_LSB(WID_LSB), .OFF_LSB(OFF_LSB)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opKind  (opKind),
    .ctrlReg (ctrlReg),
    .extWord (extWord),
    .srcAcc  (srcAcc),
    .srcReg  (srcReg),
    .dstAcc  (dstAcc),
    .resValid(resValid),
    .resAcc  (resAcc),
    .resN    (resN),
    .resZ    (resZ)
  );

  // V and C are cleared by every operation
  assign resV = 1'b0;
  assign resC = 1'b0;

  // R10
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN)) |-> (!needWord && !resValid));

endmodule

// File: tb/acc_field_unit_tb_top.sv
`timescale 1ns/1ps
module acc_field_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opKind = '0;
  logic        useImm = 1'b0;
  logic [23:0] ctrlReg = '0, extWord = '0;
  logic [55:0] srcAcc = '0, dstAcc = '0;
  logic [23:0] srcReg = '0;
  logic        needWord, resValid, resN, resZ, resV, resC;
  logic [55:0] resAcc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF0;

  always #2.5 clk = ~clk;

  acc_field_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .useImm(useImm),
    .ctrlReg(ctrlReg), .extWord(extWord), .srcAcc(srcAcc), .srcReg(srcReg),
    .dstAcc(dstAcc), .needWord(needWord), .resValid(resValid), .resAcc(resAcc),
    .resN(resN), .resZ(resZ), .resV(resV), .resC(resC)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog R7 R8: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [63:0] nextRand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  // Arithmetic reference built from R1..R5
  function automatic logic [55:0] model(input logic [1:0] k, input logic [23:0] c,
                                        input logic [55:0] s, input logic [23:0] r,
                                        input logic [55:0] d);
    int unsigned w = c[17:12];
    int unsigned o = c[5:0];
    logic [63:0] m, sh, fld, full, res;
    m = (w == 0) ? 64'd0 : ({64{1'b1}} >> (64 - w));
    if (k[1]) begin
      full = m << o;
      fld  = ({40'd0, r} & m) << o;
      res  = ({8'd0, d} & ~full) | fld;
    end else begin
      sh  = {8'd0, s} >> o;
      fld = sh & m;
      if (k[0] && w != 0 && fld[w-1]) fld = fld | ~m;
      res = fld;
    end
    return res[55:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkResult(input logic [1:0] k, input logic [23:0] c,
                             input logic [55:0] s, input logic [23:0] r,
                             input logic [55:0] d);
    logic [55:0] e = model(k, c, s, r, d);
    string tag;
    if (c[17:12] == 0)  tag = "R5 R1";
    else if (k[1])      tag = "R4 R1";
    else if (k[0])      tag = "R3 R1";
    else                tag = "R2 R1";
    check(resAcc == e, tag, {8'd0, resAcc}, {8'd0, e});
    // R6 flags
    check({resN, resZ, resV, resC} == {e[55], (e == '0), 2'b00}, "R6 flags",
          {60'd0, resN, resZ, resV, resC}, {60'd0, e[55], (e == '0), 2'b00});
  endtask

  task automatic doOp(input logic [1:0] k, input bit imm, input logic [23:0] c,
                      input logic [55:0] s, input logic [23:0] r, input logic [55:0] d);
    @(negedge clk);
    opValid = 1'b1; opKind = k; useImm = imm;
    ctrlReg = imm ? 24'hFFFFFF : c;
    extWord = imm ? 24'h000000 : 24'hFFFFFF;
    srcAcc = s; srcReg = r; dstAcc = d;
    @(negedge clk);
    if (!imm) begin
      opValid = 1'b0;
      // R7 result one cycle after issue
      check(resValid && !needWord, "R7 latency", {62'd0, resValid, needWord}, 64'd2);
      checkResult(k, c, s, r, d);
    end else begin
      // R8 extension word requested
      check(needWord && !resValid, "R8 request", {62'd0, resValid, needWord}, 64'd1);
      extWord = c;
      // R9 disturbance while needWord
      opValid = 1'b1; opKind = ~k; useImm = 1'b0; ctrlReg = 24'h00F000;
      srcAcc = ~s; srcReg = ~r; dstAcc = ~d;
      @(negedge clk);
      opValid = 1'b0;
      check(resValid && !needWord, "R8 latency", {62'd0, resValid, needWord}, 64'd2);
      checkResult(k, c, s, r, d);
      @(negedge clk);
      // R9 ignored issue gives no second result
      check(!resValid && !needWord, "R9 ignored", {62'd0, resValid, needWord}, 64'd0);
    end
  endtask

  initial begin
    int offs[12] = '{0, 1, 5, 12, 23, 31, 40, 50, 54, 55, 56, 63};
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!resValid && !needWord && resAcc == '0, "R10 reset",
          {7'd0, resValid, needWord, resAcc}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!resValid && !needWord, "R10 idle", {62'd0, resValid, needWord}, 64'd0);

    for (int w = 0; w < 64; w++) begin
      for (int oi = 0; oi < 12; oi++) begin
        for (int k = 0; k < 4; k++) begin
          logic [63:0] a = nextRand();
          logic [63:0] b = nextRand();
          logic [63:0] x = nextRand();
          // R1 junk in unused control bits
          logic [23:0] c = {x[5:0], 6'(w), x[11:6], 6'(offs[oi])};
          bit imm = ((w + oi + k) % 5) == 0;
          doOp(2'(k), imm, c, a[55:0], b[23:0], {b[63:24], a[15:0]});
        end
      end
    end

    // Directed corners: sign fill with all-ones source, empty field
    doOp(2'b01, 1'b0, 24'h001000, 56'hFF_FFFF_FFFF_FFFF, 24'h0, 56'h0);   // R3 width 1
    doOp(2'b00, 1'b1, 24'h000000, 56'hFF_FFFF_FFFF_FFFF, 24'h0, 56'h0);   // R5
    doOp(2'b10, 1'b0, 24'h018032, 56'h0, 24'hFFFFFF, 56'h12_3456_789A_BCDE); // R4 overflow top

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule